// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings. A requester presents a virtual page number, the untranslated offset bits and a write flag on a lookup port. The stored tags of all entries are compared against the page number at once. The next cycle brings a registered result: a hit flag and, on a hit, the physical address formed by placing the entry's physical page number above the offset bits. Each entry carries a reference bit, which every hit sets, and a dirty bit, which only a write hit sets.

A lookup that misses stalls the lookup port and raises a walk request carrying the missed page number toward an external page-table walker. When the walker answers with the physical page number, the block picks a slot. That slot is the lowest-numbered empty one, or, when every slot is in use, the slot named by a rotating pointer. The new mapping goes into that slot with clean status. If an older mapping was displaced, a one-cycle eviction pulse exports its page number and its reference and dirty bits so the page table can record them. The requester then repeats the lookup, which hits. A flush input empties the whole buffer in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: After reset, lk_ready is 1 and res_valid, walk_req and evict_valid are 0, and every entry is empty, so the first lookup misses.
- R2: A lookup accepted at a clock edge (lk_valid and lk_ready both 1) gives res_valid=1 exactly one cycle later. On a hit, res_hit=1 and res_paddr = {stored physical page number, lk_off}, with the page number in the upper PPN_W bits.
- R3: A miss gives res_hit=0 and res_paddr=0. From the next cycle, walk_req is 1 with walk_vpn equal to the missed page number, and lk_ready stays 0 while walk_req is 1.
- R4: fill_valid sampled while walk_req is 1 installs {walk_vpn, fill_ppn}. walk_req falls and lk_ready rises on the following cycle, and a repeated lookup of that page then hits.
- R5: fill_valid while walk_req is 0 has no effect: no entry changes, walk_req stays 0 and no eviction pulse occurs.
- R6: Every hit, read or write, sets the hit entry's reference bit. The reference bit is seen as evict_ref when that entry is later displaced.
- R7: A hit with lk_write=1 sets the entry's dirty bit, and a read hit leaves it unchanged. The dirty bit is seen as evict_dirty on displacement.
- R8: If any entry is empty at refill time, the lowest-numbered empty entry receives the mapping and evict_valid stays 0.
- R9: If all entries are in use, the victim is the entry named by a rotating pointer. The pointer starts at 0 after reset and advances by one, modulo ENTRIES, on every refill. One cycle after the refill, evict_valid pulses for exactly one cycle with the victim's page number, dirty bit and reference bit.
- R10: A flush pulse empties all entries in one cycle, so later lookups miss and the next refill takes an empty slot without an eviction pulse.
- R11: A newly installed entry starts with reference and dirty bits at 0, so displacing an entry never hit since its install reports evict_ref=0 and evict_dirty=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties every entry |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted (low during a walk) |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset bits, passed through |
| lk_write | input | 1 | Lookup is for a store |
| res_valid | output | 1 | Result present, one cycle after acceptance |
| res_hit | output | 1 | Lookup hit |
| res_paddr | output | PPN_W+OFF_W | Physical address on a hit, 0 on a miss |
| walk_req | output | 1 | Walk outstanding toward the page-table side |
| walk_vpn | output | VPN_W | Page number being walked |
| fill_valid | input | 1 | Walker answer present |
| fill_ppn | input | PPN_W | Physical page number returned by the walker |
| evict_valid | output | 1 | One-cycle pulse for a displaced mapping |
| evict_vpn | output | VPN_W | Displaced page number |
| evict_dirty | output | 1 | Displaced entry's dirty bit |
| evict_ref | output | 1 | Displaced entry's reference bit |

## Verification
The bench first fills all slots through cold misses, which shows that empty slots are taken in ascending order with no eviction. It then mixes read hits, write hits and untouched entries before forcing displacements, so the exported reference and dirty pairs (1/0, 1/1, 0/0) separate a read hit, a write hit and a fresh install. The displacement order shows whether the rotating pointer has counted every refill, including those that went into empty slots. A stray walker answer while idle and a flush followed by misses that refill without eviction cover the side paths.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_state_e;

  // Wrapping increment of a slot pointer for a buffer of n entries.
  function automatic int unsigned next_slot(input int unsigned cur, input int unsigned n);
    return (cur == n - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   cmp_vpn,
  output logic               cmp_hit,
  output logic [IDX_W-1:0]   cmp_idx,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [VPN_W-1:0]   rd_vpn,
  output logic               rd_used,
  output logic [ENTRIES-1:0] used_vec
);

  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] used_q;
  logic [ENTRIES-1:0] match_vec;

  // Parallel comparison against every occupied slot.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = used_q[g] && (tag_q[g] == cmp_vpn);
  end

  // Entries hold distinct page numbers, so at most one bit is set.
  always_comb begin
    cmp_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) cmp_idx = cmp_idx | IDX_W'(i);
    end
  end

  assign cmp_hit  = |match_vec;
  assign rd_vpn   = tag_q[rd_idx];
  assign rd_used  = used_q[rd_idx];
  assign used_vec = used_q;

  // Occupancy: flush first, then an install in the same cycle survives.
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
    end else begin
      if (flush) used_q <= '0;
      if (wr_en) used_q[wr_idx] <= 1'b1;
    end
  end

  // Tag storage carries no reset; occupancy guards it.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_vpn;
  end

endmodule

// File: rtl/tlb_ppn_store.sv
module tlb_ppn_store #(
  parameter int ENTRIES = 64,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_ppn
);

  logic [PPN_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_ppn;
  end

  assign rd_ppn = mem_q[rd_idx];

endmodule

// File: rtl/tlb_status_bits.sv
module tlb_status_bits #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic             touch_write,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             clear_en,
  input  logic [IDX_W-1:0] clear_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_ref,
  output logic             rd_dirty
);

  logic [ENTRIES-1:0] ref_q;
  logic [ENTRIES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      if (clear_en) begin
        ref_q[clear_idx]   <= 1'b0;
        dirty_q[clear_idx] <= 1'b0;
      end
      if (touch_en) begin
        ref_q[touch_idx] <= 1'b1;
        if (touch_write) dirty_q[touch_idx] <= 1'b1;
      end
    end
  end

  assign rd_ref   = ref_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] used_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx
);

  import tlb_pkg::*;

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  // Lowest-numbered empty slot wins.
  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!used_vec[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
  end

  assign victim_idx = free_any ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (advance) begin
      rr_q <= IDX_W'(next_slot(int'(rr_q), ENTRIES));
    end
  end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   lk_valid,
  output logic                   lk_ready,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  input  logic                   lk_write,
  output logic                   res_valid,
  output logic                   res_hit,
  output logic [PPN_W+OFF_W-1:0] res_paddr,
  output logic                   walk_req,
  output logic [VPN_W-1:0]       walk_vpn,
  input  logic                   fill_valid,
  input  logic [PPN_W-1:0]       fill_ppn,
  output logic                   evict_valid,
  output logic [VPN_W-1:0]       evict_vpn,
  output logic                   evict_dirty,
  output logic                   evict_ref
);

  import tlb_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PA_W  = PPN_W + OFF_W;

  walk_state_e        state_q;
  logic               accept;
  logic               hit_now;
  logic [IDX_W-1:0]   hit_idx;
  logic [PPN_W-1:0]   hit_ppn;
  logic               fill_go;
  logic [IDX_W-1:0]   victim_idx;
  logic [VPN_W-1:0]   victim_vpn;
  logic               victim_used;
  logic               victim_ref;
  logic               victim_dirty;
  logic [ENTRIES-1:0] used_vec;
  logic [VPN_W-1:0]   walk_vpn_q;

  assign lk_ready = (state_q == WALK_IDLE);
  assign walk_req = (state_q == WALK_BUSY);
  assign walk_vpn = walk_vpn_q;
  assign accept   = lk_valid && lk_ready;
  assign fill_go  = (state_q == WALK_BUSY) && fill_valid;

  tlb_tag_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .cmp_vpn  (lk_vpn),
    .cmp_hit  (hit_now),
    .cmp_idx  (hit_idx),
    .wr_en    (fill_go),
    .wr_idx   (victim_idx),
    .wr_vpn   (walk_vpn_q),
    .rd_idx   (victim_idx),
    .rd_vpn   (victim_vpn),
    .rd_used  (victim_used),
    .used_vec (used_vec)
  );

  tlb_ppn_store #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_ppn (
    .clk    (clk),
    .wr_en  (fill_go),
    .wr_idx (victim_idx),
    .wr_ppn (fill_ppn),
    .rd_idx (hit_idx),
    .rd_ppn (hit_ppn)
  );

  tlb_status_bits #(.ENTRIES(ENTRIES)) u_status (
    .clk         (clk),
    .rst         (rst),
    .touch_en    (accept && hit_now),
    .touch_write (lk_write),
    .touch_idx   (hit_idx),
    .clear_en    (fill_go),
    .clear_idx   (victim_idx),
    .rd_idx      (victim_idx),
    .rd_ref      (victim_ref),
    .rd_dirty    (victim_dirty)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst        (rst),
    .used_vec   (used_vec),
    .advance    (fill_go),
    .victim_idx (victim_idx)
  );

  // Lookup result, registered one cycle after acceptance.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_valid <= accept;
      res_hit   <= accept && hit_now;
      res_paddr <= (accept && hit_now) ? {hit_ppn, lk_off} : PA_W'(0);
    end
  end

  // Walk control: a miss opens a walk, the walker answer closes it.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= WALK_IDLE;
      walk_vpn_q <= '0;
    end else if (accept && !hit_now) begin
      state_q    <= WALK_BUSY;
      walk_vpn_q <= lk_vpn;
    end else if (fill_go) begin
      state_q    <= WALK_IDLE;
    end
  end

  // Eviction report for a displaced, occupied slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_dirty <= 1'b0;
      evict_ref   <= 1'b0;
    end else begin
      evict_valid <= fill_go && victim_used;
      if (fill_go && victim_used) begin
        evict_vpn   <= victim_vpn;
        evict_dirty <= victim_dirty;
        evict_ref   <= victim_ref;
      end
    end
  end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk (
  input logic clk,
  input logic rst,
  input logic lk_valid,
  input logic lk_ready,
  input logic res_valid,
  input logic res_hit,
  input logic walk_req,
  input logic fill_valid,
  input logic evict_valid
);

  // R2: an accepted lookup yields a result on the next cycle
  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> res_valid);

  // R2: no result without an accepted lookup
  a_r2_no_stray_result: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && lk_ready) |=> !res_valid);

  // R2: a hit flag only accompanies a result
  a_r2_hit_with_result: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);

  // R3: lookups stall while a walk is outstanding
  a_r3_stall_on_walk: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> !lk_ready);

  // R3: a walk stays open until answered
  a_r3_walk_holds: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !fill_valid) |=> walk_req);

  // R4: an answered walk closes on the next cycle
  a_r4_walk_closes: assert property (@(posedge clk) disable iff (rst)
    (walk_req && fill_valid) |=> !walk_req);

  // R9: an eviction pulse only follows an answered walk
  a_r9_evict_after_fill: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> $past(walk_req && fill_valid));

  // R5: without an open walk, no eviction pulse follows
  a_r5_idle_fill_quiet: assert property (@(posedge clk) disable iff (rst)
    !walk_req |=> !evict_valid);

endmodule

bind tlb_fa tlb_fa_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_valid    (lk_valid),
  .lk_ready    (lk_ready),
  .res_valid   (res_valid),
  .res_hit     (res_hit),
  .walk_req    (walk_req),
  .fill_valid  (fill_valid),
  .evict_valid (evict_valid)
);

// File: tb/tlb_fa_test.sv
module tlb_fa_test;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 64;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int OFF_W = 12;
  localparam int PA_W  = PPN_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flush = 1'b0;
  logic             lk_valid = 1'b0;
  logic             lk_ready;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [OFF_W-1:0] lk_off = '0;
  logic             lk_write = 1'b0;
  logic             res_valid;
  logic             res_hit;
  logic [PA_W-1:0]  res_paddr;
  logic             walk_req;
  logic [VPN_W-1:0] walk_vpn;
  logic             fill_valid = 1'b0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic             evict_valid;
  logic [VPN_W-1:0] evict_vpn;
  logic             evict_dirty;
  logic             evict_ref;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  typedef struct packed {
    logic            hit;
    logic [PA_W-1:0] pa;
  } exp_t;

  exp_t  exp_q [$];
  string req_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_fa #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) uut (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_write(lk_write), .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .fill_valid(fill_valid), .fill_ppn(fill_ppn),
    .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_dirty(evict_dirty),
    .evict_ref(evict_ref)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: compares each result against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "result with nothing expected", 64'(res_hit), 64'd0);
      end else begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(res_hit == e.hit, r, "res_hit", 64'(res_hit), 64'(e.hit));
        check(res_paddr == e.pa, r, "res_paddr", 64'(res_paddr), 64'(e.pa));
      end
    end
  end

  // Driver: one lookup, expectation pushed before it is accepted.
  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        input bit wr, input bit hit, input logic [PPN_W-1:0] ppn,
                        input string req);
    exp_t e;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vpn   = vpn;
    lk_off   = off;
    lk_write = wr;
    e.hit = hit;
    e.pa  = hit ? {ppn, off} : '0;
    exp_q.push_back(e);
    req_q.push_back(req);
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
    lk_write = 1'b0;
  endtask

  // Miss, walk, answer, and the expected eviction report.
  task automatic miss_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                           input bit ev, input logic [VPN_W-1:0] ev_vpn,
                           input bit ev_d, input bit ev_r, input string req);
    lookup(vpn, 12'h000, 1'b0, 1'b0, '0, "R3");
    @(negedge clk);
    check(walk_req == 1'b1, "R3", "walk_req", 64'(walk_req), 64'd1);
    check(walk_vpn == vpn, "R3", "walk_vpn", 64'(walk_vpn), 64'(vpn));
    check(lk_ready == 1'b0, "R3", "lk_ready during walk", 64'(lk_ready), 64'd0);
    fill_valid = 1'b1;
    fill_ppn   = ppn;
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
    @(negedge clk);
    check(walk_req == 1'b0, "R4", "walk_req after fill", 64'(walk_req), 64'd0);
    check(lk_ready == 1'b1, "R4", "lk_ready after fill", 64'(lk_ready), 64'd1);
    check(evict_valid == ev, req, "evict_valid", 64'(evict_valid), 64'(ev));
    if (ev) begin
      check(evict_vpn == ev_vpn, req, "evict_vpn", 64'(evict_vpn), 64'(ev_vpn));
      check(evict_dirty == ev_d, req, "evict_dirty", 64'(evict_dirty), 64'(ev_d));
      check(evict_ref == ev_r, req, "evict_ref", 64'(evict_ref), 64'(ev_r));
      @(negedge clk);
      check(evict_valid == 1'b0, "R9", "evict pulse width", 64'(evict_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(lk_ready == 1'b1, "R1", "lk_ready", 64'(lk_ready), 64'd1);
    check(res_valid == 1'b0, "R1", "res_valid", 64'(res_valid), 64'd0);
    check(walk_req == 1'b0, "R1", "walk_req", 64'(walk_req), 64'd0);
    check(evict_valid == 1'b0, "R1", "evict_valid", 64'(evict_valid), 64'd0);

    // R8: cold fills take slots 0..N-1 in order with no eviction (first miss covers R1)
    for (int i = 0; i < N; i++) begin
      miss_fill(VPN_W'(32'h100 + i), PPN_W'(32'h5000 + i), 1'b0, '0, 1'b0, 1'b0, "R8");
    end

    // R2/R4: hits return {ppn, offset}
    lookup(20'h00100, 12'habc, 1'b0, 1'b1, 20'h05000, "R2");
    lookup(20'h00101, 12'h123, 1'b1, 1'b1, 20'h05001, "R2");
    lookup(20'h0013f, 12'hfff, 1'b0, 1'b1, 20'h0503f, "R4");
    lookup(20'h00105, 12'h001, 1'b1, 1'b1, 20'h05005, "R7");
    lookup(20'h00105, 12'h002, 1'b0, 1'b1, 20'h05005, "R6");

    // R5: a walker answer while idle is ignored
    @(negedge clk);
    fill_valid = 1'b1;
    fill_ppn   = 20'hdead0;
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
    @(negedge clk);
    check(walk_req == 1'b0, "R5", "walk_req after idle fill", 64'(walk_req), 64'd0);
    check(evict_valid == 1'b0, "R5", "evict after idle fill", 64'(evict_valid), 64'd0);
    lookup(20'h00100, 12'h010, 1'b0, 1'b1, 20'h05000, "R5");

    // R9: full buffer; rotating pointer wrapped to slot 0 after N refills
    miss_fill(20'h00900, 20'h09000, 1'b1, 20'h00100, 1'b0, 1'b1, "R6");
    miss_fill(20'h00901, 20'h09001, 1'b1, 20'h00101, 1'b1, 1'b1, "R7");
    miss_fill(20'h00902, 20'h09002, 1'b1, 20'h00102, 1'b0, 1'b0, "R11");
    miss_fill(20'h00903, 20'h09003, 1'b1, 20'h00103, 1'b0, 1'b0, "R9");
    miss_fill(20'h00904, 20'h09004, 1'b1, 20'h00104, 1'b0, 1'b0, "R9");
    miss_fill(20'h00905, 20'h09005, 1'b1, 20'h00105, 1'b1, 1'b1, "R9");
    lookup(20'h00900, 12'h555, 1'b0, 1'b1, 20'h09000, "R4");
    lookup(20'h00106, 12'h555, 1'b0, 1'b1, 20'h05006, "R9");

    // R10: flush empties everything; refills take free slots, no eviction
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    miss_fill(20'h00900, 20'h0a000, 1'b0, '0, 1'b0, 1'b0, "R10");
    lookup(20'h00900, 12'h777, 1'b0, 1'b1, 20'h0a000, "R10");
    miss_fill(20'h00106, 20'h0a106, 1'b0, '0, 1'b0, 1'b0, "R10");
    lookup(20'h00106, 12'h042, 1'b1, 1'b1, 20'h0a106, "R10");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", "results outstanding", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule